// File: doc/BRIEF.md
# Cell-Granular Multi-Queue Write Admission

This block sits on the receive side of a cell-oriented slave interface and steers incoming words into four word queues. A sender polls the block with an address that names one queue, or a group of queues for multicast, and the block answers with a cell-available flag. The flag is high only when every chosen queue can hold a whole cell of the programmed length. Space is granted per cell: a cell that has begun is always allowed to finish.

A cell begins with a word carrying both enable and start-of-cell. Each later word comes with enable alone. The cell closes by itself once the programmed number of words has been written. While a cell is open, the flag looks ahead to the next cell. If no further cell fits in the chosen queues, the flag falls a fixed number of cycles before the last word. Each queue counts its committed occupancy in cells and in words, and this count grows only when a cell completes. A release pulse from the reading side gives back one cell. Words that arrive outside a cell are dropped and raise a sticky error flag.

Top module: `cell_wr_admit`

## Requirements
- R1: With no cell open and address bit 4 low, address bits 3..0 give a queue index. Values 0 to 3 select that single queue, and values 4 to 15 select no queue. `clav` is high exactly when a queue is selected and `128 - occ_words` of that queue is at least `cell_len`.
- R2: With no cell open and address bit 4 high, address bits 3..0 form a destination mask, where bit n selects queue n. `clav` is high only when the mask is nonzero and every selected queue has room for one full cell.
- R3: When no cell is open, a clock edge with `wr_enb` and `wr_soc` high and `clav` high opens a cell and writes that word to every selected queue. While the cell is open, each edge with `wr_enb` high writes the next word. The selection is held for the whole cell, and `wr_soc` and `wr_addr` are ignored until the cell closes.
- R4: The cell closes on the edge that writes word number `cell_len`. After that, words with `wr_enb` high and `wr_soc` low are not stored and change no occupancy.
- R5: While a cell is open with w words already written, `clav` is high when w+5 < `cell_len`, or when every queue of the cell could hold two more cells. Otherwise it is low, so a refused next cell sees `clav` low at least four cycles before the last word.
- R6: `orphan_err` is set by any edge with `wr_enb` high while no cell is open, unless that edge opens a cell. Once set, only reset clears it.
- R7: On the edge that writes the last word, `occ_cells` rises by 1 and `occ_words` rises by `cell_len` for each queue of the cell. A `cell_release` bit lowers its queue by one cell and by `cell_len` words when that queue's cell count is nonzero, and it is ignored when the count is zero. Each field is 8 bits wide, and queue n sits at bits 8n+7..8n.
- R8: Every written word is stored at the queue's write pointer, which starts at 0 after reset and wraps modulo 128. `rd_data` shows the stored word at `rd_addr` of queue `rd_q` without delay.
- R9: After reset, all occupancies and `orphan_err` are 0, no cell is open, and `clav` follows R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_len | input | 8 | Words per cell, 16 to 128, changed only while all queues are empty |
| wr_addr | input | 5 | Queue index or multicast mask |
| wr_enb | input | 1 | Word strobe |
| wr_soc | input | 1 | Marks the first word of a cell |
| wr_data | input | 9 | Word to store |
| clav | output | 1 | Cell-available flag |
| orphan_err | output | 1 | Sticky flag for dropped words |
| cell_release | input | 4 | One cell freed per queue by the reading side |
| occ_words | output | 32 | Committed words per queue, 8 bits each |
| occ_cells | output | 32 | Committed cells per queue, 8 bits each |
| rd_q | input | 2 | Queue selected for the storage read port |
| rd_addr | input | 7 | Entry selected for the storage read port |
| rd_data | output | 9 | Stored word |

## Verification
Single-queue cells are pushed into one queue until it is full. The bench checks `clav` on every word of the final cell, which shows whether the flag falls on the word count where it must and no earlier. Multicast masks are mixed so that one selected queue is full while another has room, which separates an all-of-mask check from an any-of-mask check. Unmapped indices, orphan words and words sent after a cell has closed test the dropping rules. Random traffic with random gaps, random releases and random cell lengths between drains is compared with a bench model on every cycle, and a final read-back of all stored words confirms the write pointers and multicast replication.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int NQ_DEF     = 4;
  localparam int DEPTH_DEF  = 128;
  localparam int DW_DEF     = 9;
  localparam int ADDR_W_DEF = 5;
  localparam int EARLY_DEF  = 4;
endpackage

// File: rtl/cwa_addr_dec.sv
module cwa_addr_dec #(
  parameter int NQ     = cwa_pkg::NQ_DEF,
  parameter int ADDR_W = cwa_pkg::ADDR_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NQ-1:0]     mask
);
  localparam int IW = ADDR_W - 1;

  logic [IW-1:0] idx;
  assign idx = addr[IW-1:0];

  always_comb begin
    if (addr[ADDR_W-1]) begin
      mask = addr[NQ-1:0];
    end else if (idx < IW'(NQ)) begin
      mask = NQ'(1) << idx;
    end else begin
      mask = '0;
    end
  end

  always_comb begin
    a_mask_card: assert ($isunknown(addr) || addr[ADDR_W-1] || $countones(mask) <= 1);
  end
endmodule

// File: rtl/cwa_queue.sv
module cwa_queue #(
  parameter int DEPTH = cwa_pkg::DEPTH_DEF,
  parameter int DW    = cwa_pkg::DW_DEF,
  parameter int LEN_W = $clog2(DEPTH + 1),
  parameter int OCC_W = $clog2(DEPTH + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cell_len,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             commit,
  input  logic             release_i,
  output logic [OCC_W-1:0] occ_words,
  output logic [OCC_W-1:0] occ_cells,
  output logic             room_one,
  output logic             room_two,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  localparam int SW = OCC_W + 2;

  logic [OCC_W-1:0] occ_w_q, occ_w_d;
  logic [OCC_W-1:0] occ_c_q, occ_c_d;
  logic [AW-1:0]    wptr_q, wptr_d;
  logic             rel_ok;
  logic [OCC_W-1:0] len_o;
  logic [SW-1:0]    sum_one, sum_two;
  logic [DW-1:0]    mem [DEPTH];

  assign len_o   = OCC_W'(cell_len);
  assign rel_ok  = release_i && (occ_c_q != '0);
  assign sum_one = SW'(occ_w_q) + SW'(cell_len);
  assign sum_two = sum_one + SW'(cell_len);
  assign room_one = (sum_one <= SW'(DEPTH));
  assign room_two = (sum_two <= SW'(DEPTH));

  always_comb begin
    occ_w_d = occ_w_q;
    occ_c_d = occ_c_q;
    if (commit) begin
      occ_w_d = occ_w_d + len_o;
      occ_c_d = occ_c_d + OCC_W'(1);
    end
    if (rel_ok) begin
      occ_w_d = occ_w_d - len_o;
      occ_c_d = occ_c_d - OCC_W'(1);
    end
    wptr_d = wr_en ? (wptr_q + AW'(1)) : wptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_w_q <= '0;
      occ_c_q <= '0;
      wptr_q  <= '0;
    end else begin
      occ_w_q <= occ_w_d;
      occ_c_q <= occ_c_d;
      wptr_q  <= wptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wptr_q] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_addr];
  assign occ_words = occ_w_q;
  assign occ_cells = occ_c_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_w_q <= OCC_W'(DEPTH));

  // R7
  commit_cells_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !release_i) |=> (occ_c_q == $past(occ_c_q) + OCC_W'(1)));

  // R8
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr_q == AW'($past(wptr_q) + AW'(1))));
endmodule

// File: rtl/cwa_ctrl.sv
module cwa_ctrl #(
  parameter int NQ    = cwa_pkg::NQ_DEF,
  parameter int LEN_W = 8,
  parameter int EARLY = cwa_pkg::EARLY_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cell_len,
  input  logic             enb,
  input  logic             soc,
  input  logic [NQ-1:0]    sel_mask,
  input  logic [NQ-1:0]    room_one,
  input  logic [NQ-1:0]    room_two,
  output logic [NQ-1:0]    wr_vec,
  output logic [NQ-1:0]    commit_vec,
  output logic             clav,
  output logic             err
);
  logic             open_q, open_d;
  logic [NQ-1:0]    mask_q, mask_d;
  logic [LEN_W-1:0] wcnt_q, wcnt_d;
  logic             err_q, err_d;
  logic             admit_ok, next_ok, early_ok;
  logic             start, last;

  assign admit_ok = (sel_mask != '0) && (&(room_one | ~sel_mask));
  assign next_ok  = &(room_two | ~mask_q);
  assign early_ok = ({1'b0, wcnt_q} + (LEN_W+1)'(EARLY + 1)) < {1'b0, cell_len};
  assign start    = !open_q && enb && soc && admit_ok;
  assign last     = open_q && enb && (wcnt_q == (cell_len - LEN_W'(1)));

  always_comb begin
    clav       = open_q ? (early_ok || next_ok) : admit_ok;
    wr_vec     = '0;
    if (start) begin
      wr_vec = sel_mask;
    end else if (open_q && enb) begin
      wr_vec = mask_q;
    end
    commit_vec = last ? mask_q : '0;
  end

  always_comb begin
    open_d = open_q;
    mask_d = mask_q;
    wcnt_d = wcnt_q;
    err_d  = err_q;
    if (start) begin
      open_d = 1'b1;
      mask_d = sel_mask;
      wcnt_d = LEN_W'(1);
    end else if (open_q && enb) begin
      if (last) begin
        open_d = 1'b0;
        wcnt_d = '0;
      end else begin
        wcnt_d = wcnt_q + LEN_W'(1);
      end
    end else if (!open_q && enb) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      mask_q <= '0;
      wcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      mask_q <= mask_d;
      wcnt_q <= wcnt_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (wcnt_q < cell_len));

  // R3
  open_needs_soc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !(enb && soc)) |=> !open_q);

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !last) |=> $stable(mask_q));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/cell_wr_admit.sv
module cell_wr_admit #(
  parameter int NQ     = cwa_pkg::NQ_DEF,
  parameter int DEPTH  = cwa_pkg::DEPTH_DEF,
  parameter int DW     = cwa_pkg::DW_DEF,
  parameter int ADDR_W = cwa_pkg::ADDR_W_DEF,
  parameter int EARLY  = cwa_pkg::EARLY_DEF,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int QI_W  = $clog2(NQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cell_len,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_enb,
  input  logic                wr_soc,
  input  logic [DW-1:0]       wr_data,
  output logic                clav,
  output logic                orphan_err,
  input  logic [NQ-1:0]       cell_release,
  output logic [NQ*OCC_W-1:0] occ_words,
  output logic [NQ*OCC_W-1:0] occ_cells,
  input  logic [QI_W-1:0]     rd_q,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data
);
  logic          rst_m, rst_s;
  logic [NQ-1:0] sel_mask, room_one, room_two, wr_vec, commit_vec;
  logic [DW-1:0] rd_vec [NQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  cwa_addr_dec #(.NQ(NQ), .ADDR_W(ADDR_W)) u_dec (
    .addr (wr_addr),
    .mask (sel_mask)
  );

  cwa_ctrl #(.NQ(NQ), .LEN_W(LEN_W), .EARLY(EARLY)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .cell_len   (cell_len),
    .enb        (wr_enb),
    .soc        (wr_soc),
    .sel_mask   (sel_mask),
    .room_one   (room_one),
    .room_two   (room_two),
    .wr_vec     (wr_vec),
    .commit_vec (commit_vec),
    .clav       (clav),
    .err        (orphan_err)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    cwa_queue #(.DEPTH(DEPTH), .DW(DW), .LEN_W(LEN_W), .OCC_W(OCC_W), .AW(AW)) u_queue (
      .clk       (clk),
      .rst_n     (rst_s),
      .cell_len  (cell_len),
      .wr_en     (wr_vec[q]),
      .wr_data   (wr_data),
      .commit    (commit_vec[q]),
      .release_i (cell_release[q]),
      .occ_words (occ_words[q*OCC_W +: OCC_W]),
      .occ_cells (occ_cells[q*OCC_W +: OCC_W]),
      .room_one  (room_one[q]),
      .room_two  (room_two[q]),
      .rd_addr   (rd_addr),
      .rd_data   (rd_vec[q])
    );
  end

  assign rd_data = rd_vec[rd_q];
endmodule

// File: tb/cell_wr_admit_bench.sv
`timescale 1ns/1ps
module cell_wr_admit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cell_len;
  logic [4:0]  wr_addr;
  logic        wr_enb, wr_soc;
  logic [8:0]  wr_data;
  logic        clav, orphan_err;
  logic [3:0]  cell_release;
  logic [31:0] occ_words, occ_cells;
  logic [1:0]  rd_q;
  logic [6:0]  rd_addr;
  logic [8:0]  rd_data;

  always #2.5 clk = ~clk;

  cell_wr_admit u_cell_wr_admit (
    .clk(clk), .rst_n(rst_n), .cell_len(cell_len), .wr_addr(wr_addr),
    .wr_enb(wr_enb), .wr_soc(wr_soc), .wr_data(wr_data), .clav(clav),
    .orphan_err(orphan_err), .cell_release(cell_release),
    .occ_words(occ_words), .occ_cells(occ_cells),
    .rd_q(rd_q), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_occw [4];
  int m_occc [4];
  int m_wptr [4];
  int m_mem  [4][128];
  bit m_val  [4][128];
  bit m_open, m_err;
  int m_mask, m_cnt;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dec(input logic [4:0] a);
    if (a[4]) return int'(a[3:0]);
    if (a[3:0] < 4) return 1 << a[3:0];
    return 0;
  endfunction

  function automatic bit fits(input int mask, input int ncell);
    for (int q = 0; q < 4; q++)
      if (mask[q] && (m_occw[q] + ncell * int'(cell_len) > 128)) return 0;
    return 1;
  endfunction

  function automatic bit exp_clav(input logic [4:0] a);
    if (m_open) return ((m_cnt + 5) < int'(cell_len)) || fits(m_mask, 2);
    return (dec(a) != 0) && fits(dec(a), 1);
  endfunction

  task automatic step(input bit e, input bit s, input logic [4:0] a,
                      input logic [8:0] d, input logic [3:0] rel);
    bit start, last;
    int wm;
    wr_enb = e; wr_soc = s; wr_addr = a; wr_data = d; cell_release = rel;
    #1;
    if (m_open) chk("R5 clav open", int'(clav), int'(exp_clav(a)));
    else if (a[4]) chk("R2 clav multicast", int'(clav), int'(exp_clav(a)));
    else chk("R1 clav single", int'(clav), int'(exp_clav(a)));
    chk("R6 orphan_err", int'(orphan_err), int'(m_err));
    for (int q = 0; q < 4; q++) begin
      chk("R7 occ_words", int'(occ_words[q*8 +: 8]), m_occw[q]);
      chk("R7 occ_cells", int'(occ_cells[q*8 +: 8]), m_occc[q]);
    end
    start = !m_open && e && s && (dec(a) != 0) && fits(dec(a), 1);
    last  = m_open && e && (m_cnt == int'(cell_len) - 1);
    wm    = m_open ? m_mask : dec(a);
    if (start || (m_open && e))
      for (int q = 0; q < 4; q++)
        if (wm[q]) begin
          m_mem[q][m_wptr[q]] = int'(d);
          m_val[q][m_wptr[q]] = 1;
          m_wptr[q] = (m_wptr[q] + 1) % 128;
        end
    if (!m_open && e && !start) m_err = 1;
    for (int q = 0; q < 4; q++) begin
      int c0 = m_occc[q];
      if (last && m_mask[q]) begin m_occc[q]++; m_occw[q] += int'(cell_len); end
      if (rel[q] && c0 > 0) begin m_occc[q]--; m_occw[q] -= int'(cell_len); end
    end
    if (start) begin m_open = 1; m_mask = dec(a); m_cnt = 1; end
    else if (m_open && e) begin
      if (last) begin m_open = 0; m_cnt = 0; end
      else m_cnt++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input logic [4:0] a);
    step(0, 0, a, 9'd0, 4'd0);
  endtask

  task automatic send_cell(input logic [4:0] a);
    for (int i = 0; i < int'(cell_len); i++)
      step(1, i == 0, a, 9'($urandom), 4'd0);
  endtask

  task automatic drain();
    for (int k = 0; k < 10; k++) step(0, 0, 5'd0, 9'd0, 4'hF);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int q = 0; q < 4; q++) begin
      m_occw[q] = 0; m_occc[q] = 0; m_wptr[q] = 0;
      for (int j = 0; j < 128; j++) m_val[q][j] = 0;
    end
    m_open = 0; m_err = 0; m_mask = 0; m_cnt = 0;
    rst_n = 1'b0; cell_len = 8'd16; wr_addr = '0; wr_enb = 0; wr_soc = 0;
    wr_data = '0; cell_release = '0; rd_q = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    #1;
    chk("R9 clav after reset", int'(clav), 1);
    chk("R9 err after reset", int'(orphan_err), 0);
    chk("R9 occupancy after reset", int'(occ_words), 0);
    @(negedge clk);

    // R1 unmapped index selects nothing
    idle(5'b01000);
    // R6 orphan word
    step(1, 0, 5'd2, 9'h1AA, 4'd0);
    idle(5'd2);
    chk("R6 err set by orphan", int'(orphan_err), 1);

    // R5 fill queue 0 and watch the early drop in the last cell
    for (int c = 0; c < 7; c++) send_cell(5'd0);
    for (int i = 0; i < 16; i++) begin
      #1;
      if (i > 0) chk("R5 early drop point", int'(clav), (i < 11) ? 1 : 0);
      #0;
      step(1, i == 0, 5'd0, 9'(i + 300), 4'd0);
    end
    idle(5'd0);
    chk("R1 full queue refused", int'(clav), 0);
    chk("R7 queue 0 cells", int'(occ_cells[7:0]), 8);

    // R2 mask with a full member vs free members
    wr_addr = 5'b10011; #1;
    chk("R2 mask with full queue", int'(clav), 0);
    wr_addr = 5'b10000; #1;
    chk("R2 empty mask", int'(clav), 0);
    @(negedge clk);
    send_cell(5'b10110);
    // R4 extra words after the cell are dropped
    step(1, 0, 5'b10110, 9'h055, 4'd0);
    step(1, 0, 5'b10110, 9'h056, 4'd0);
    idle(5'd1);
    chk("R4 no extra words", int'(occ_words[15:8]), 16);
    // R7 release brings room back
    step(0, 0, 5'd0, 9'd0, 4'b0001);
    idle(5'd0);
    chk("R7 release restores clav", int'(clav), 1);
    // R7 release of empty queue ignored
    step(0, 0, 5'd3, 9'd0, 4'b1000);
    idle(5'd3);
    chk("R7 empty release ignored", int'(occ_words[31:24]), 0);

    // longest cell: next never fits
    drain();
    cell_len = 8'd128;
    send_cell(5'd3);
    idle(5'd3);
    drain();

    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      cell_len = 8'(16 + ($urandom % 25));
      for (int n = 0; n < 3000; n++) begin
        logic [3:0] rel;
        rel = 4'(($urandom % 8 == 0) ? ($urandom % 16) : 0);
        if (m_open)
          step(($urandom % 4) != 0, ($urandom % 8) == 0, 5'($urandom), 9'($urandom), rel);
        else
          step(($urandom % 3) == 0, ($urandom % 4) != 0, 5'($urandom % 20), 9'($urandom), rel);
      end
      while (m_open) step(1, 0, 5'd0, 9'($urandom), 4'd0);
      drain();
    end

    // R8 readback of every stored word
    for (int q = 0; q < 4; q++)
      for (int j = 0; j < 128; j++)
        if (m_val[q][j]) begin
          rd_q = 2'(q); rd_addr = 7'(j); #0.2;
          chk("R8 stored word", int'(rd_data), m_mem[q][j]);
        end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule